// File: doc/BRIEF.md
# Bus Cycle Response Monitor

This block guards every bus cycle against a missing reply. A cycle is marked by a level strobe that the master raises at the start and lowers at the end. While the strobe is high, the block counts clocks and waits for one of two reply sources: a data transfer acknowledge or an autovector acknowledge. If either one arrives in time, monitoring stops quietly. If neither arrives before the selected limit, the block raises a bus error toward the master and sets a sticky timeout flag.

A 2-bit select input picks the limit. Smaller codes give longer windows: 64, 32, 16 or 8 clocks. The select is sampled once, when the cycle starts. The bus error stays high until the master lowers the strobe. The sticky flag stays set until a clear input is pulsed. A global enable turns monitoring off completely.

Top module: `bmon_top`

## Requirements
- R1: After reset, `bus_err` and `tmo_flag` are both 0.
- R2: A cycle starts at the first clock edge where `mon_en` and `cyc_act` are sampled high in idle; call that edge E0. A `xfer_ack` sampled high at any edge from E0 up to E0+N ends monitoring, and `bus_err` then stays 0 for the rest of the cycle.
- R3: `vec_ack` ends monitoring in exactly the same way as `xfer_ack`.
- R4: The window N is decoded from `tmo_sel` as 2'b00=64, 2'b01=32, 2'b10=16 and 2'b11=8 clocks. With no acknowledge at edges E0..E0+N, `bus_err` goes to 1 right after edge E0+N, and it is still 0 after edge E0+N-1.
- R5: `tmo_sel` is captured at E0. Changes to it later in the same cycle do not alter that cycle's window.
- R6: Once raised, `bus_err` stays 1 while `cyc_act` stays high. It returns to 0 right after the first edge where `cyc_act` is sampled low.
- R7: When `mon_en` is low, `bus_err` is 0 from the next edge onward and no timing takes place. Dropping `mon_en` during a cycle aborts that cycle without an error.
- R8: `tmo_flag` is set at the same edge where `bus_err` rises. It holds until an edge where `flag_clr` is high. If a timeout and a clear happen at the same edge, the set wins.
- R9: After an acknowledge, holding `cyc_act` high does not restart timing. A new cycle needs `cyc_act` to be sampled low first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_en | input | 1 | Monitoring enable |
| cyc_act | input | 1 | Bus cycle strobe, high for the whole cycle |
| xfer_ack | input | 1 | Data transfer acknowledge |
| vec_ack | input | 1 | Autovector acknowledge |
| tmo_sel | input | 2 | Timeout window select (00 is the longest) |
| flag_clr | input | 1 | Clears the sticky timeout flag |
| bus_err | output | 1 | Bus error toward the master |
| tmo_flag | output | 1 | Sticky record that a timeout occurred |

## Verification
The hardest cases sit right at the window edge. An acknowledge that arrives at edge E0+N must prevent the error, while silence through that same edge must raise it. Random cycles therefore draw the acknowledge delay around every one of the four windows, including delays 0, N and N+1, and they also change the select in the middle of a cycle. A second hard case is a timeout edge that lines up with a clear pulse. Directed sequences cover it, along with a long strobe held after an acknowledge and an enable dropped in the middle of a wait.

// File: rtl/bmon_pkg.sv
package bmon_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_DONE  = 2'd2,
    ST_FAULT = 2'd3
  } bmon_state_e;
endpackage

// File: rtl/bmon_limit_dec.sv
// Inverse decode: smallest code gives the longest window.
module bmon_limit_dec #(
  parameter int BASE = 8,
  parameter int SELW = 2,
  parameter int CW   = 7
) (
  input  logic [SELW-1:0] sel,
  output logic [CW-1:0]   lim
);
  localparam int MAXSH = (1 << SELW) - 1;
  logic [SELW-1:0] sh;

  always_comb begin
    sh  = SELW'(MAXSH) - sel;
    lim = CW'(BASE) << sh;
  end
endmodule

// File: rtl/bmon_timer.sv
module bmon_timer #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [CW-1:0] lim_in,
  output logic          expire
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] lim_q, lim_d;

  always_comb begin
    cnt_d = cnt_q;
    lim_d = lim_q;
    if (load) begin
      cnt_d = '0;
      lim_d = lim_in;
    end else if (step) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (load || step) begin
      cnt_q <= cnt_d;
      lim_q <= lim_d;
    end
  end

  assign expire = (cnt_q == (lim_q - 1'b1));
endmodule

// File: rtl/bmon_fsm.sv
module bmon_fsm
  import bmon_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic cyc,
  input  logic ack_any,
  input  logic expire,
  input  logic clr,
  output logic load,
  output logic step,
  output logic err,
  output logic flag
);
  bmon_state_e st_q, st_d;
  logic        flag_d;
  logic        set_flag;

  always_comb begin
    st_d     = st_q;
    load     = 1'b0;
    step     = 1'b0;
    set_flag = 1'b0;
    if (!en) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (cyc) begin
            if (ack_any) st_d = ST_DONE;
            else begin
              st_d = ST_WAIT;
              load = 1'b1;
            end
          end
        end
        ST_WAIT: begin
          if (!cyc)         st_d = ST_IDLE;
          else if (ack_any) st_d = ST_DONE;
          else if (expire) begin
            st_d     = ST_FAULT;
            set_flag = 1'b1;
          end else step = 1'b1;
        end
        ST_DONE:  if (!cyc) st_d = ST_IDLE;
        ST_FAULT: if (!cyc) st_d = ST_IDLE;
        default:  st_d = ST_IDLE;
      endcase
    end
    flag_d = set_flag | (flag & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      flag <= 1'b0;
    end else begin
      st_q <= st_d;
      flag <= flag_d;
    end
  end

  assign err = (st_q == ST_FAULT);
endmodule

// File: rtl/bmon_top.sv
module bmon_top #(
  parameter int BASE_CLKS = 8,
  parameter int SEL_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mon_en,
  input  logic             cyc_act,
  input  logic             xfer_ack,
  input  logic             vec_ack,
  input  logic [SEL_W-1:0] tmo_sel,
  input  logic             flag_clr,
  output logic             bus_err,
  output logic             tmo_flag
);
  localparam int MAX_CLKS = BASE_CLKS << ((1 << SEL_W) - 1);
  localparam int CW       = $clog2(MAX_CLKS) + 1;

  logic [CW-1:0] lim;
  logic          load, step, expire;

  bmon_limit_dec #(.BASE(BASE_CLKS), .SELW(SEL_W), .CW(CW)) u_dec (
    .sel(tmo_sel),
    .lim(lim)
  );

  bmon_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .lim_in(lim), .expire(expire)
  );

  bmon_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .en(mon_en), .cyc(cyc_act),
    .ack_any(xfer_ack | vec_ack), .expire(expire), .clr(flag_clr),
    .load(load), .step(step), .err(bus_err), .flag(tmo_flag)
  );
endmodule

// File: rtl/bmon_chk.sv
module bmon_chk #(
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mon_en,
  input logic             cyc_act,
  input logic             xfer_ack,
  input logic             vec_ack,
  input logic [SEL_W-1:0] tmo_sel,
  input logic             flag_clr,
  input logic             bus_err,
  input logic             tmo_flag
);
  p_ack_noerr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_err && xfer_ack) |=> !bus_err);
  p_vec_noerr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_err && vec_ack) |=> !bus_err);
  p_err_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err && cyc_act && mon_en) |=> bus_err);
  p_err_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_act |=> !bus_err);
  p_no_err_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_en |=> !bus_err);
  p_flag_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_err) |-> tmo_flag);
  p_flag_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_flag && !flag_clr) |=> tmo_flag);
endmodule

bind bmon_top bmon_chk #(.SEL_W(SEL_W)) u_chk (.*);

// File: tb/sim_bmon_top.sv
`timescale 1ns/1ps
module sim_bmon_top;
  logic clk = 1'b0;
  logic rst_n, mon_en, cyc_act, xfer_ack, vec_ack, flag_clr;
  logic [1:0] tmo_sel;
  logic bus_err, tmo_flag;
  int n_chk = 0, n_bad = 0, n_clk = 0;
  bit model_flag = 1'b0;

  always #2.5 clk = ~clk;

  bmon_top u0 (.*);

  function automatic int win(input logic [1:0] s);
    return 64 >> s;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    n_clk++;
    if (n_clk > 150000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<150000", n_clk);
      summary();
    end
  end

  // d: the acknowledge is high only before edge E0+d; d = 255 means none.
  task automatic run_cyc(input logic [1:0] s, input int d, input bit use_vec,
                         input bit wobble, input int hold, input bit clr_at_to,
                         input string req);
    int n = win(s);
    bit err_exp = (d > n);
    @(negedge clk);
    cyc_act = 1'b1; tmo_sel = s;
    xfer_ack = (d == 0) && !use_vec; vec_ack = (d == 0) && use_vec;
    flag_clr = clr_at_to && (n == 0);
    for (int i = 0; i <= n + 2 + hold; i++) begin
      @(negedge clk);
      chk(req, bus_err, err_exp && (i >= n));
      if (wobble) tmo_sel = 2'($urandom);
      xfer_ack = (i + 1 == d) && !use_vec;
      vec_ack  = (i + 1 == d) && use_vec;
      flag_clr = clr_at_to && (i + 1 == n);
    end
    if (err_exp) model_flag = 1'b1;
    chk("R8", tmo_flag, model_flag);
    xfer_ack = 0; vec_ack = 0; flag_clr = 0; cyc_act = 0;
    @(negedge clk);
    chk("R6", bus_err, 1'b0);
  endtask

  task automatic pulse_clr();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    model_flag = 1'b0;
    chk("R8 clear", tmo_flag, 1'b0);
  endtask

  initial begin
    void'($urandom(32'h1bad5eed));
    rst_n = 0; mon_en = 1; cyc_act = 0; xfer_ack = 0; vec_ack = 0;
    flag_clr = 0; tmo_sel = 0;
    #12;
    chk("R1", bus_err, 1'b0);
    chk("R1", tmo_flag, 1'b0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R1", bus_err, 1'b0);

    // R4: every window, silent and acked on the last allowed edge
    for (int s = 0; s < 4; s++) begin
      run_cyc(2'(s), 255, 0, 0, 2, 0, "R4");
      run_cyc(2'(s), win(2'(s)), 0, 0, 2, 0, "R2 last edge");
      run_cyc(2'(s), win(2'(s)) + 1, 1, 0, 1, 0, "R4 late ack");
    end
    pulse_clr();
    // R2/R3 at the start edge
    run_cyc(2'b11, 0, 0, 0, 4, 0, "R2 start ack");
    run_cyc(2'b11, 0, 1, 0, 4, 0, "R3 start vec");
    // R9: ack then hold the strobe long
    run_cyc(2'b11, 3, 1, 0, 90, 0, "R9");
    // R8: timeout coincides with clear, set wins
    run_cyc(2'b10, 255, 0, 0, 1, 1, "R8 set wins");
    pulse_clr();
    // R5: select wobbles after the start
    run_cyc(2'b00, 255, 0, 1, 1, 0, "R5");
    run_cyc(2'b11, 255, 0, 1, 1, 0, "R5");
    pulse_clr();

    // R7: disabled, silent strobe
    @(negedge clk); mon_en = 0; cyc_act = 1; tmo_sel = 2'b11;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk("R7 disabled", bus_err, 1'b0);
    end
    cyc_act = 0; @(negedge clk); mon_en = 1;
    // R7: abort mid-wait
    @(negedge clk); cyc_act = 1;
    for (int i = 0; i < 4; i++) @(negedge clk);
    mon_en = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk("R7 abort", bus_err, 1'b0);
    end
    cyc_act = 0; @(negedge clk); mon_en = 1;
    @(negedge clk);
    chk("R7 flag", tmo_flag, 1'b0);

    // random cycles around the window edges
    for (int k = 0; k < 120; k++) begin
      logic [1:0] s = 2'($urandom);
      int r = $urandom_range(0, 5);
      int d;
      case (r)
        0: d = 0;
        1: d = win(s);
        2: d = win(s) + 1;
        3: d = 255;
        default: d = $urandom_range(0, 70);
      endcase
      run_cyc(s, d, 1'($urandom), 1'($urandom), $urandom_range(0, 3), 0,
              d > win(s) ? "R4 rand" : (d == 0 ? "R2 rand" : "R3 rand"));
      if ($urandom_range(0, 3) == 0) pulse_clr();
    end
    summary();
  end
endmodule